// File: doc/BRIEF.md
# Double-Buffered Output Gamma Table

This block applies an output gamma curve to a stream of pixels with three colour channels. Each channel has its own lookup array. Every array exists twice, as bank A and bank B, so a complete new curve can be loaded into the bank that is not in use while the other bank keeps translating pixels. The host programs the block through a small register write port. That port exposes a control register, a table-control register, a write index and a data register. The current mode and the current bank are driven out as live status.

The requested mode and bank are held in shadow registers. They become the working configuration only on the clock edge where `frameStart` is high, so a bank swap never lands in the middle of a frame. Software reads the current bank from the status outputs, loads the other bank, then requests that bank. A data write goes through a per-channel mask, so the three channel arrays can be filled either together or one at a time. Each data write stores one entry and moves the write index on by one.

A loaded curve consists of the fitted points plus one closing entry. That closing entry holds the last base value plus its delta. The table depth `DEPTH` counts this closing entry. In table mode, the top `log2(DEPTH)` bits of each input channel choose the entry for that channel. No interpolation is done between entries.

Top module: `gamma_pingpong_lut`

## Requirements
- R1: After reset the following values hold: current mode 0, current bank 0, pixel outputs 0, output valid low, write mask 3'b111, write bank A and write index 0.
- R2: The mode field is `regWrData[1:0]` of register address 0. Value 0 selects bypass and value 2 selects table lookup. The reserved values 1 and 3 behave exactly like bypass.
- R3: In bypass, each output channel and `pixValidOut` equal the matching inputs from one clock earlier.
- R4: In table mode, each output channel one clock later is the entry of that channel's array at index `pixIn[DATA_W-1 -: log2(DEPTH)]`. The entry comes from the bank in use.
- R5: The pixel bank bit is `regWrData[4]` of address 0. Value 0 applies bank A to pixels and value 1 applies bank B.
- R6: The host bank bit is `regWrData[4]` of address 1. It picks the bank that data writes go to, independently of the pixel bank. Writes into the bank not in use leave the pixel outputs unchanged.
- R7: The write mask is `regWrData[2:0]` of address 1. Bit 2 enables red, bit 1 green and bit 0 blue. A data write changes only the arrays whose bit is set.
- R8: A write to address 2 sets the write index to the written value. A write to address 3 stores `regWrData[DATA_W-1:0]` at the index and adds one to the index.
- R9: Once the index reaches `DEPTH`, it stays at `DEPTH` and data writes store nothing. An index write of `DEPTH` or more sets the index to `DEPTH`.
- R10: Mode and bank writes go to shadow registers. `curModeOut` and `curSelOut` take the shadow values only on an edge where `frameStart` is high, and they hold otherwise. A control write on the same edge as `frameStart` becomes current only at the next frame start.
- R11: A pixel sampled on the same edge as `frameStart` is translated with the configuration from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 table control, 2 index, 3 data |
| regWrData | input | 16 | Register write data |
| frameStart | input | 1 | Frame boundary pulse that commits shadow mode and bank |
| pixValidIn | input | 1 | Input pixel valid |
| pixRIn | input | DATA_W | Red input |
| pixGIn | input | DATA_W | Green input |
| pixBIn | input | DATA_W | Blue input |
| pixValidOut | output | 1 | Output pixel valid |
| pixROut | output | DATA_W | Red output |
| pixGOut | output | DATA_W | Green output |
| pixBOut | output | DATA_W | Blue output |
| curModeOut | output | 2 | Mode in use |
| curSelOut | output | 1 | Pixel bank in use |

## Verification
The hardest situations to reach are the edge collisions. The bench has to place a `frameStart` pulse on the same clock as a pixel, or on the same clock as a control write, so that the old-versus-new configuration rule is actually exercised. Directed tasks line those events up on one negative edge. A random phase then mixes frame pulses with data, index and control writes, including the reserved mode codes.

Running the write index past the end is also hard to reach from the ports. The bench parks the index at the last entry, then writes a large index value. Afterwards it confirms through the pixel path that entry 0 never wrapped.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  localparam int REG_W = 16;

  localparam logic [1:0] ADDR_CTRL    = 2'd0;
  localparam logic [1:0] ADDR_LUTCTRL = 2'd1;
  localparam logic [1:0] ADDR_INDEX   = 2'd2;
  localparam logic [1:0] ADDR_DATA    = 2'd3;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_RSVD1  = 2'd1,
    MODE_TABLE  = 2'd2,
    MODE_RSVD3  = 2'd3
  } gammaMode_t;

  // Write strobes from control to datapath
  typedef struct packed {
    logic       wrEn;
    logic       bank;     // 0 = bank A, 1 = bank B
    logic [2:0] chMask;   // [2] red, [1] green, [0] blue
  } lutWrStb_t;

endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               frameStart,
  output lutWrStb_t          wrStb,
  output logic [ADDR_W:0]    wrPtr,
  output gammaMode_t         curMode,
  output logic               curSel
);

  localparam logic [ADDR_W:0]  PTR_END = (ADDR_W+1)'(DEPTH);
  localparam logic [REG_W-1:0] DEPTH_R = REG_W'(DEPTH);

  gammaMode_t shMode;
  logic       shSel;
  logic [2:0] wrMask;
  logic       hostSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shMode  <= MODE_BYPASS;
      shSel   <= 1'b0;
      curMode <= MODE_BYPASS;
      curSel  <= 1'b0;
      wrMask  <= 3'b111;
      hostSel <= 1'b0;
      wrPtr   <= '0;
    end else begin
      if (frameStart) begin
        curMode <= shMode;
        curSel  <= shSel;
      end
      if (regWrEn) begin
        case (regAddr)
          ADDR_CTRL: begin
            shMode <= gammaMode_t'(regWrData[1:0]);
            shSel  <= regWrData[4];
          end
          ADDR_LUTCTRL: begin
            wrMask  <= regWrData[2:0];
            hostSel <= regWrData[4];
          end
          ADDR_INDEX: begin
            wrPtr <= (regWrData >= DEPTH_R) ? PTR_END : regWrData[ADDR_W:0];
          end
          default: begin
            if (wrPtr != PTR_END) wrPtr <= wrPtr + 1'b1;
          end
        endcase
      end
    end
  end

  always_comb begin
    wrStb.wrEn   = regWrEn && (regAddr == ADDR_DATA);
    wrStb.bank   = hostSel;
    wrStb.chMask = wrMask;
  end

endmodule

// File: rtl/gamma_lut_datapath.sv
module gamma_lut_datapath
  import gamma_lut_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  lutWrStb_t              wrStb,
  input  logic [ADDR_W:0]        wrPtr,
  input  logic [DATA_W-1:0]      wrData,
  input  gammaMode_t             curMode,
  input  logic                   curSel,
  input  logic                   pixValidIn,
  input  logic [2:0][DATA_W-1:0] pixIn,
  output logic                   pixValidOut,
  output logic [2:0][DATA_W-1:0] pixOut
);

  localparam logic [ADDR_W:0] PTR_END = (ADDR_W+1)'(DEPTH);

  logic              wrHit;
  logic [ADDR_W-1:0] wrIdx;
  logic              useTable;

  assign wrHit    = wrStb.wrEn && (wrPtr < PTR_END);
  assign wrIdx    = wrPtr[ADDR_W-1:0];
  assign useTable = (curMode == MODE_TABLE);

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    logic [DATA_W-1:0] bankA [DEPTH];
    logic [DATA_W-1:0] bankB [DEPTH];
    logic [ADDR_W-1:0] rdIdx;
    logic [DATA_W-1:0] rdVal;
    logic [DATA_W-1:0] outReg;

    always_ff @(posedge clk) begin
      if (wrHit && wrStb.chMask[ch]) begin
        if (wrStb.bank) bankB[wrIdx] <= wrData;
        else            bankA[wrIdx] <= wrData;
      end
    end

    assign rdIdx = pixIn[ch][DATA_W-1 -: ADDR_W];
    assign rdVal = curSel ? bankB[rdIdx] : bankA[rdIdx];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outReg <= '0;
      else       outReg <= useTable ? rdVal : pixIn[ch];
    end

    assign pixOut[ch] = outReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixValidOut <= 1'b0;
    else       pixValidOut <= pixValidIn;
  end

endmodule

// File: rtl/gamma_pingpong_lut.sv
module gamma_pingpong_lut
  import gamma_lut_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [15:0]       regWrData,
  input  logic              frameStart,
  input  logic              pixValidIn,
  input  logic [DATA_W-1:0] pixRIn,
  input  logic [DATA_W-1:0] pixGIn,
  input  logic [DATA_W-1:0] pixBIn,
  output logic              pixValidOut,
  output logic [DATA_W-1:0] pixROut,
  output logic [DATA_W-1:0] pixGOut,
  output logic [DATA_W-1:0] pixBOut,
  output logic [1:0]        curModeOut,
  output logic              curSelOut
);

  localparam int ADDR_W = $clog2(DEPTH);

  lutWrStb_t              wrStb;
  logic [ADDR_W:0]        wrPtr;
  gammaMode_t             curMode;
  logic                   curSel;
  logic [2:0][DATA_W-1:0] pixInBus;
  logic [2:0][DATA_W-1:0] pixOutBus;

  gamma_lut_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .frameStart (frameStart),
    .wrStb      (wrStb),
    .wrPtr      (wrPtr),
    .curMode    (curMode),
    .curSel     (curSel)
  );

  assign pixInBus = {pixRIn, pixGIn, pixBIn};

  gamma_lut_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrStb       (wrStb),
    .wrPtr       (wrPtr),
    .wrData      (regWrData[DATA_W-1:0]),
    .curMode     (curMode),
    .curSel      (curSel),
    .pixValidIn  (pixValidIn),
    .pixIn       (pixInBus),
    .pixValidOut (pixValidOut),
    .pixOut      (pixOutBus)
  );

  assign pixROut    = pixOutBus[2];
  assign pixGOut    = pixOutBus[1];
  assign pixBOut    = pixOutBus[0];
  assign curModeOut = curMode;
  assign curSelOut  = curSel;

endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic              frameStart,
  input logic              pixValidIn,
  input logic [DATA_W-1:0] pixRIn,
  input logic [DATA_W-1:0] pixGIn,
  input logic [DATA_W-1:0] pixBIn,
  input logic              pixValidOut,
  input logic [DATA_W-1:0] pixROut,
  input logic [DATA_W-1:0] pixGOut,
  input logic [DATA_W-1:0] pixBOut,
  input logic [1:0]        curModeOut,
  input logic              curSelOut,
  input logic [ADDR_W:0]   wrPtr
);

  localparam logic [ADDR_W:0] PTR_END = (ADDR_W+1)'(DEPTH);

  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(curModeOut) && $stable(curSelOut)); // R10

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    pixValidIn |=> pixValidOut); // R3

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (curModeOut != 2'd2) |=>
      {pixROut, pixGOut, pixBOut} == $past({pixRIn, pixGIn, pixBIn})); // R2

  AST_PTR_SAT: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= PTR_END); // R9

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd3 && wrPtr < PTR_END) |=>
      wrPtr == (ADDR_W+1)'($past(wrPtr) + 1'b1)); // R8

endmodule

bind gamma_pingpong_lut gamma_lut_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .frameStart  (frameStart),
  .pixValidIn  (pixValidIn),
  .pixRIn      (pixRIn),
  .pixGIn      (pixGIn),
  .pixBIn      (pixBIn),
  .pixValidOut (pixValidOut),
  .pixROut     (pixROut),
  .pixGOut     (pixGOut),
  .pixBOut     (pixBOut),
  .curModeOut  (curModeOut),
  .curSelOut   (curSelOut),
  .wrPtr       (wrPtr)
);

// File: tb/tb_gamma_pingpong_lut.sv
`timescale 1ns/1ps
module tb_gamma_pingpong_lut;

  localparam int DW = 10;
  localparam int DP = 64;
  localparam int SH = DW - 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic frameStart = 1'b0;
  logic pixValidIn = 1'b0;
  logic [DW-1:0] pixRIn = '0, pixGIn = '0, pixBIn = '0;
  logic pixValidOut;
  logic [DW-1:0] pixROut, pixGOut, pixBOut;
  logic [1:0] curModeOut;
  logic curSelOut;

  always #2.5 clk = ~clk;

  gamma_pingpong_lut #(.DATA_W(DW), .DEPTH(DP)) dut (.*);

  int checks = 0;
  int fails = 0;

  // Bench model
  logic [DW-1:0] mA [3][DP];
  logic [DW-1:0] mB [3][DP];
  int shModeM = 0, shSelM = 0, curModeM = 0, curSelM = 0;
  int maskM = 7, hostM = 0, ptrM = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expPix(int ch, int v);
    if (curModeM != 2) return v;
    return curSelM ? int'(mB[ch][v >> SH]) : int'(mA[ch][v >> SH]);
  endfunction

  task automatic modelWrite(int a, int d);
    case (a)
      0: begin shModeM = d & 3; shSelM = (d >> 4) & 1; end
      1: begin maskM = d & 7; hostM = (d >> 4) & 1; end
      2: ptrM = (d >= DP) ? DP : d;
      default: begin
        if (ptrM < DP) begin
          for (int ch = 0; ch < 3; ch++)
            if ((maskM >> ch) & 1) begin
              if (hostM != 0) mB[ch][ptrM] = DW'(d);
              else            mA[ch][ptrM] = DW'(d);
            end
          ptrM++;
        end
      end
    endcase
  endtask

  task automatic regWr(int a, int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'(a); regWrData = 16'(d);
    modelWrite(a, d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frameStart = 1'b1;
    curModeM = shModeM; curSelM = shSelM;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // channel index: 2 red, 1 green, 0 blue
  task automatic pixChk(string req, int r, int g, int b);
    @(negedge clk);
    pixValidIn = 1'b1; pixRIn = DW'(r); pixGIn = DW'(g); pixBIn = DW'(b);
    @(posedge clk); #1;
    chk(req, int'(pixValidOut), 1);
    chk(req, int'(pixROut), expPix(2, r));
    chk(req, int'(pixGOut), expPix(1, g));
    chk(req, int'(pixBOut), expPix(0, b));
    @(negedge clk);
    pixValidIn = 1'b0;
  endtask

  task automatic entryChk(string req, int idx);
    int v;
    v = idx << SH;
    pixChk(req, v, v, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 mode", int'(curModeOut), 0);
    chk("R1 sel", int'(curSelOut), 0);
    chk("R1 valid", int'(pixValidOut), 0);
    chk("R1 pix", int'({pixROut, pixGOut, pixBOut}), 0);
    @(negedge clk); rstN = 1'b1;

    // R3 bypass
    for (int i = 0; i < 8; i++)
      pixChk("R3 bypass", int'($urandom % 1024), int'($urandom % 1024), int'($urandom % 1024));

    // R1 default mask 7, bank A, index 0: load bank A all channels (R8)
    for (int i = 0; i < DP; i++) regWr(3, int'($urandom % 1024));
    regWr(0, 2);  // table, bank A
    // R10 shadow not yet current
    #1 chk("R10 shadow held", int'(curModeOut), 0);
    pixChk("R10 before frame", 100, 200, 300);
    frame();
    chk("R10 mode committed", int'(curModeOut), 2);
    chk("R10 sel committed", int'(curSelOut), 0);
    for (int i = 0; i < 8; i++)
      pixChk("R4 table bank A", int'($urandom % 1024), int'($urandom % 1024), int'($urandom % 1024));
    for (int i = 0; i < DP; i++) entryChk("R8 index walk", i);

    // Load bank B one channel at a time (R7) while A is live (R6)
    for (int c = 2; c >= 0; c--) begin
      regWr(1, (1 << 4) | (1 << c));
      regWr(2, 0);
      for (int i = 0; i < DP; i++) regWr(3, int'($urandom % 1024));
      pixChk("R6 inactive bank write", int'($urandom % 1024), int'($urandom % 1024), int'($urandom % 1024));
    end
    regWr(0, 2 | (1 << 4));
    frame();
    chk("R5 sel B", int'(curSelOut), 1);
    for (int i = 0; i < 8; i++)
      pixChk("R5 table bank B", int'($urandom % 1024), int'($urandom % 1024), int'($urandom % 1024));

    // R7 green-only write to live bank B entry 5
    regWr(1, (1 << 4) | 3'b010);
    regWr(2, 5);
    regWr(3, 16'h2a5);
    entryChk("R7 green only", 5);

    // R9 end of table
    regWr(1, (1 << 4) | 3'b111);
    regWr(2, DP - 1);
    regWr(3, 16'h111);
    regWr(3, 16'h222);
    entryChk("R9 last entry", DP - 1);
    entryChk("R9 no wrap", 0);
    regWr(2, 100);
    regWr(3, 16'h333);
    entryChk("R9 index saturates", 0);
    entryChk("R9 index saturates last", DP - 1);

    // R2 reserved modes
    regWr(0, 1 | (1 << 4)); frame();
    pixChk("R2 mode1 bypass", 11, 522, 1000);
    regWr(0, 3 | (1 << 4)); frame();
    pixChk("R2 mode3 bypass", 700, 3, 64);
    regWr(0, 0); frame();
    pixChk("R2 mode0 bypass", 1, 2, 3);

    // R11 pixel in frame-start cycle uses old config
    regWr(0, 2);
    @(negedge clk);
    frameStart = 1'b1; pixValidIn = 1'b1;
    pixRIn = 10'd300; pixGIn = 10'd600; pixBIn = 10'd900;
    @(posedge clk); #1;
    chk("R11 old config", int'(pixROut), 300);
    chk("R11 old config", int'(pixGOut), 600);
    curModeM = shModeM; curSelM = shSelM;
    @(negedge clk); frameStart = 1'b0; pixValidIn = 1'b0;
    pixChk("R11 new config", 300, 600, 900);

    // R10 control write on frame-start edge waits a frame
    @(negedge clk);
    frameStart = 1'b1; regWrEn = 1'b1; regAddr = 2'd0; regWrData = 16'h0010;
    curModeM = shModeM; curSelM = shSelM;
    modelWrite(0, 16'h0010);
    @(negedge clk); frameStart = 1'b0; regWrEn = 1'b0;
    chk("R10 collide mode", int'(curModeOut), 2);
    chk("R10 collide sel", int'(curSelOut), 0);
    frame();
    chk("R10 next frame mode", int'(curModeOut), 0);
    chk("R10 next frame sel", int'(curSelOut), 1);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 4)      pixChk("R4 random", int'($urandom % 1024), int'($urandom % 1024), int'($urandom % 1024));
      else if (op < 6) regWr(3, int'($urandom % 1024));
      else if (op == 6) regWr(2, int'($urandom % 80));
      else if (op == 7) regWr(1, int'($urandom % 32) & 16'h17);
      else if (op == 8) regWr(0, int'($urandom % 32) & 16'h13);
      else begin
        frame();
        chk("R10 random mode", int'(curModeOut), curModeM);
        chk("R10 random sel", int'(curSelOut), curSelM);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule